// File: doc/BRIEF.md
# Timer Interrupt Status and Routing Unit

This unit sits behind a bank of timer channels and turns their fire strobes into interrupts. Each timer carries a small configuration word. That word selects whether the interrupt is a one-cycle edge pulse, a level line held until software acknowledges it, or a message write. A level interrupt sets that timer's bit in a shared status register. Software clears the bit by writing one to it. The unit drives a vector of interrupt lines indexed by route number, and it offers message requests on a valid/ready stream.

On every configuration write, the route is checked against a mask of allowed lines derived from the number of lines. An illegal route is replaced by route 0, which means not connected. A configuration change can leave a held level interrupt with nobody to acknowledge it. This happens when the change disables the interrupt, switches it to edge or message mode, or moves it to another line. In each of these cases the unit drops the held status bit, which releases the line.

Message back-pressure: once `msg_valid_o` is high, the address and data stay frozen until a cycle in which `msg_ready_i` is also high. Several timers may be waiting at once. The request on offer is always the one from the lowest-numbered waiting timer, and a new offer can follow an accepted one directly. A timer that fires again while its message is still waiting adds nothing.

Top module: `tirq_route_unit`

## Requirements
- R1: After reset the status register, all interrupt lines and `msg_valid_o` are 0. Each timer's 64-bit config readback is {allowed mask, 32'h0000_8010} for a message-capable timer and {allowed mask, 32'h0000_0010} otherwise. The allowed mask is 0 below 20 lines, 4'hF shifted to the top four lines for 20 to 31 lines, and 32'hFF00_0000 for 32 or more lines.
- R2: A fire on a timer whose interrupt-enable bit (config bit 2) is 0 produces no line activity, no status bit and no message.
- R3: With bit 2 set, level bit (config bit 1) clear, message inactive and a nonzero route in bits 13:9, a fire pulses interrupt line `route` high for exactly one cycle and leaves the status register unchanged.
- R4: With config bit 1 set, a fire sets the timer's status bit and holds line `route` high. Further fires on that timer while its status bit is set change nothing.
- R5: A status write with a mask clears every status bit whose mask bit is 1 and drops the line it held. Mask bits of 0 leave their status bits untouched.
- R6: A config write that selects a route whose bit is clear in the allowed mask stores route 0. A fire with route 0 in edge or level mode drives no line and sets no status bit.
- R7: Writes cannot change the read-only config bits: the allowed mask in 63:32, periodic-capable bit 4 (reads 1), size bit 5 (reads 0) and message-capable bit 15. Bit 8 (32-bit mode) always reads 0. Bits 1, 2, 3 and 14 and the route field are writable.
- R8: Message mode is active only when both message-capable bit 15 and message-enable bit 14 are 1. In that mode a fire sends a message whose address is bits 63:32 of the timer's message register and whose data is bits 31:0, and it drives no line and sets no status bit.
- R9: A config write clears a held status bit, dropping its line, when the new value disables the interrupt, selects edge mode, activates message mode, or changes the effective route. A rewrite with identical settings keeps the bit.
- R10: Timers that message in the same cycle are offered one at a time in ascending timer order. While valid is high and ready low, address and data stay stable.
- R11: A fire on a timer whose message is waiting but not yet offered does not create a second message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fire_i | input | NT | One-cycle fire strobe per timer |
| cfg_we_i | input | 1 | Config low-word write strobe |
| cfg_sel_i | input | SEL_W | Timer selected for config write |
| cfg_wdata_i | input | 32 | Config low-word write data |
| cfg_rsel_i | input | SEL_W | Timer selected for config readback |
| cfg_rdata_o | output | 64 | Config readback of selected timer |
| msg_we_i | input | 1 | Message register write strobe |
| msg_sel_i | input | SEL_W | Timer selected for message register write |
| msg_wdata_i | input | 64 | Message register value {address, data} |
| sts_clr_i | input | 1 | Status write-one-to-clear strobe |
| sts_clr_mask_i | input | NT | Bits to clear |
| sts_o | output | NT | Level interrupt status |
| irq_o | output | NLINES | Interrupt lines by route number |
| msg_valid_o | output | 1 | Message request valid |
| msg_ready_i | input | 1 | Message request accepted |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
Fires are applied under each delivery choice: disabled, edge, level, message, and message enabled on a timer without the message capability. A pulse that vanishes after one cycle tells edge from level, and a status bit with no line tells a bad route from a good one. Config rewrites are tried with identical settings and with each of the four releasing changes, so a missing or over-eager drop shows on the status bits. A three-timer simultaneous burst against a stalled consumer, with a repeat fire during the stall, separates correct ordering and merging from duplicate or reordered messages.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int unsigned CB_LVL    = 1;
  localparam int unsigned CB_IEN    = 2;
  localparam int unsigned CB_PER    = 3;
  localparam int unsigned CB_RT_LO  = 9;
  localparam int unsigned RT_W      = 5;
  localparam int unsigned CB_MEN    = 14;

  // allowed-line mask as a function of the number of interrupt lines
  function automatic logic [31:0] allowed_lines(input int unsigned n);
    if (n >= 32)      return 32'hFF00_0000;
    else if (n >= 20) return 32'h0000_000F << (n - 4);
    else              return 32'h0;
  endfunction
endpackage

// File: rtl/tirq_cfg_slot.sv
module tirq_cfg_slot
  import tirq_pkg::*;
#(
  parameter int unsigned IDX     = 0,
  parameter int unsigned SEL_W   = 3,
  parameter logic [31:0] ALLOWED = 32'h0,
  parameter bit          MSG_CAP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic             msg_we,
  input  logic [SEL_W-1:0] msg_sel,
  input  logic [63:0]      msg_wdata,
  output logic             ien_o,
  output logic             lvl_o,
  output logic             msg_act_o,
  output logic [RT_W-1:0]  eff_route_o,
  output logic             drop_o,
  output logic [63:0]      cfg_word_o,
  output logic [63:0]      msg_word_o
);
  logic            r_lvl, r_ien, r_per, r_men;
  logic [RT_W-1:0] r_route;
  logic [63:0]     r_msg;

  logic            wr;
  logic            c_lvl, c_ien, c_men, new_act;
  logic [RT_W-1:0] c_route, new_route, new_eff;

  assign wr      = cfg_we && (cfg_sel == SEL_W'(IDX));
  assign c_lvl   = cfg_wdata[CB_LVL];
  assign c_ien   = cfg_wdata[CB_IEN];
  assign c_men   = cfg_wdata[CB_MEN];
  assign c_route = cfg_wdata[CB_RT_LO +: RT_W];

  // route legality: 0 always legal, otherwise its bit must be in the mask
  assign new_route = ((c_route == '0) || ALLOWED[c_route]) ? c_route : '0;
  assign new_act   = MSG_CAP && c_men;
  assign new_eff   = new_act ? '0 : new_route;

  assign msg_act_o   = MSG_CAP && r_men;
  assign eff_route_o = msg_act_o ? '0 : r_route;
  assign ien_o       = r_ien;
  assign lvl_o       = r_lvl;

  // a held level bit must go when the write removes its owner path
  assign drop_o = wr && (!c_ien || new_act || !c_lvl || (new_eff != eff_route_o));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_lvl   <= 1'b0;
      r_ien   <= 1'b0;
      r_per   <= 1'b0;
      r_men   <= 1'b0;
      r_route <= '0;
    end else if (wr) begin
      r_lvl   <= c_lvl;
      r_ien   <= c_ien;
      r_per   <= cfg_wdata[CB_PER];
      r_men   <= c_men;
      r_route <= new_route;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      r_msg <= '0;
    else if (msg_we && (msg_sel == SEL_W'(IDX)))
      r_msg <= msg_wdata;
  end

  assign cfg_word_o = {ALLOWED, 16'h0, MSG_CAP, r_men, r_route, 3'b000,
                       1'b0, 1'b1, r_per, r_ien, r_lvl, 1'b0};
  assign msg_word_o = r_msg;
endmodule

// File: rtl/tirq_msg_arb.sv
module tirq_msg_arb #(
  parameter int unsigned NT = 8,
  localparam int unsigned SW = $clog2(NT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NT-1:0]        req_i,
  input  logic [NT-1:0][63:0]  words_i,
  input  logic                 ready_i,
  output logic                 valid_o,
  output logic [31:0]          addr_o,
  output logic [31:0]          data_o
);
  logic [NT-1:0] pend_q, gone;
  logic [SW-1:0] gidx;
  logic          load;

  always_comb begin
    gidx = '0;
    for (int i = NT - 1; i >= 0; i--)
      if (pend_q[i]) gidx = SW'(i);
  end

  assign load = (|pend_q) && (!valid_o || ready_i);
  assign gone = load ? (NT'(1) << gidx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      pend_q <= (pend_q & ~gone) | req_i;
      if (load) begin
        valid_o <= 1'b1;
        addr_o  <= words_i[gidx][63:32];
        data_o  <= words_i[gidx][31:0];
      end else if (ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tirq_route_unit.sv
module tirq_route_unit
  import tirq_pkg::*;
#(
  parameter int unsigned NT           = 8,
  parameter int unsigned NLINES       = 32,
  parameter logic [31:0] MSG_CAP_MASK = 32'hFFFF_FFFF,
  localparam int unsigned SEL_W       = $clog2(NT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NT-1:0]     fire_i,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic [SEL_W-1:0]  cfg_rsel_i,
  output logic [63:0]       cfg_rdata_o,
  input  logic              msg_we_i,
  input  logic [SEL_W-1:0]  msg_sel_i,
  input  logic [63:0]       msg_wdata_i,
  input  logic              sts_clr_i,
  input  logic [NT-1:0]     sts_clr_mask_i,
  output logic [NT-1:0]     sts_o,
  output logic [NLINES-1:0] irq_o,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [31:0]       msg_addr_o,
  output logic [31:0]       msg_data_o
);
  localparam logic [31:0] ALLOWED = allowed_lines(NLINES);

  logic [NT-1:0]            ien, lvl, act, drop;
  logic [NT-1:0][RT_W-1:0]  eff;
  logic [NT-1:0][63:0]      cfg_words, msg_words;
  logic [NT-1:0]            fire_ok, msg_req, lvl_set, pulse_req, clr_m;
  logic [NLINES-1:0]        lvl_lines, pulse_n, pulse_q;

  for (genvar g = 0; g < NT; g++) begin : g_slot
    tirq_cfg_slot #(
      .IDX(g), .SEL_W(SEL_W), .ALLOWED(ALLOWED), .MSG_CAP(MSG_CAP_MASK[g])
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we_i), .cfg_sel(cfg_sel_i), .cfg_wdata(cfg_wdata_i),
      .msg_we(msg_we_i), .msg_sel(msg_sel_i), .msg_wdata(msg_wdata_i),
      .ien_o(ien[g]), .lvl_o(lvl[g]), .msg_act_o(act[g]),
      .eff_route_o(eff[g]), .drop_o(drop[g]),
      .cfg_word_o(cfg_words[g]), .msg_word_o(msg_words[g])
    );

    assign fire_ok[g]   = fire_i[g] && ien[g] && !sts_o[g];
    assign msg_req[g]   = fire_ok[g] && act[g];
    assign lvl_set[g]   = fire_ok[g] && !act[g] && lvl[g] && (eff[g] != '0);
    assign pulse_req[g] = fire_ok[g] && !act[g] && !lvl[g] && (eff[g] != '0);
  end

  assign clr_m = sts_clr_i ? sts_clr_mask_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) sts_o <= '0;
    else        sts_o <= (sts_o & ~clr_m & ~drop) | lvl_set;
  end

  // line fan-in: line 0 means unconnected and is never driven
  always_comb begin
    lvl_lines = '0;
    pulse_n   = '0;
    for (int l = 1; l < NLINES; l++)
      for (int i = 0; i < NT; i++) begin
        if (eff[i] == RT_W'(l)) begin
          lvl_lines[l] = lvl_lines[l] | sts_o[i];
          pulse_n[l]   = pulse_n[l] | pulse_req[i];
        end
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= pulse_n;
  end

  assign irq_o = lvl_lines | pulse_q;

  assign cfg_rdata_o = (int'(cfg_rsel_i) < NT) ? cfg_words[cfg_rsel_i] : '0;

  tirq_msg_arb #(.NT(NT)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_i(msg_req), .words_i(msg_words),
    .ready_i(msg_ready_i), .valid_o(msg_valid_o),
    .addr_o(msg_addr_o), .data_o(msg_data_o)
  );
endmodule

// File: rtl/tirq_route_chk.sv
module tirq_route_chk #(
  parameter int unsigned NT     = 8,
  parameter int unsigned NLINES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NT-1:0]     fire_i,
  input logic              sts_clr_i,
  input logic [NT-1:0]     sts_clr_mask_i,
  input logic [NT-1:0]     sts_o,
  input logic [NLINES-1:0] irq_o,
  input logic              msg_valid_o,
  input logic              msg_ready_i,
  input logic [31:0]       msg_addr_o,
  input logic [31:0]       msg_data_o
);
  // R4: a status bit can only rise in the cycle after a fire on that timer
  a_r4_rise_needs_fire: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_o & ~$past(sts_o) & ~$past(fire_i)) == '0));

  // R4: a held status bit always keeps some line high
  a_r4_held_drives_line: assert property (@(posedge clk) disable iff (!rst_n)
    (|sts_o) |-> (|irq_o));

  // R5: bits written with 1 are gone on the next cycle
  a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr_i && |(sts_clr_mask_i & sts_o)) |=>
      ((sts_o & $past(sts_clr_mask_i) & $past(sts_o)) == '0));

  // R10: an offer that is not taken stays frozen
  a_r10_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && !msg_ready_i) |=>
      (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)));
endmodule

bind tirq_route_unit tirq_route_chk #(.NT(NT), .NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .fire_i(fire_i), .sts_clr_i(sts_clr_i),
  .sts_clr_mask_i(sts_clr_mask_i), .sts_o(sts_o), .irq_o(irq_o),
  .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i),
  .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o)
);

// File: tb/test_tirq_route_unit.sv
module test_tirq_route_unit;
  localparam int unsigned NT = 4;
  localparam int unsigned NL = 24;
  localparam int unsigned SW = 2;
  localparam logic [31:0] ALW = 32'h00F0_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] fire = '0;
  logic          cfg_we = 1'b0;
  logic [SW-1:0] cfg_sel = '0, cfg_rsel = '0, msg_sel = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [63:0]   cfg_rdata;
  logic          msg_we = 1'b0;
  logic [63:0]   msg_wdata = '0;
  logic          sts_clr = 1'b0;
  logic [NT-1:0] sts_mask = '0;
  logic [NT-1:0] sts;
  logic [NL-1:0] irq;
  logic          msg_valid, msg_ready = 1'b1;
  logic [31:0]   msg_addr, msg_data;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [63:0] expq[$];

  always #5ns clk = ~clk;

  tirq_route_unit #(.NT(NT), .NLINES(NL), .MSG_CAP_MASK(32'hFFFF_FFF7)) i_tirq_route_unit (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .cfg_rsel_i(cfg_rsel), .cfg_rdata_o(cfg_rdata),
    .msg_we_i(msg_we), .msg_sel_i(msg_sel), .msg_wdata_i(msg_wdata),
    .sts_clr_i(sts_clr), .sts_clr_mask_i(sts_mask), .sts_o(sts), .irq_o(irq),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
    .msg_addr_o(msg_addr), .msg_data_o(msg_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  function automatic logic [31:0] cw(input bit lv, input bit en, input logic [4:0] rt, input bit me);
    return (32'(lv) << 1) | (32'(en) << 2) | (32'(rt) << 9) | (32'(me) << 14);
  endfunction

  task automatic wr_cfg(input int t, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = SW'(t); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_msg(input int t, input logic [63:0] d);
    msg_we = 1'b1; msg_sel = SW'(t); msg_wdata = d;
    @(negedge clk);
    msg_we = 1'b0;
  endtask

  task automatic do_fire(input logic [NT-1:0] m);
    fire = m;
    @(negedge clk);
    fire = '0;
  endtask

  task automatic clr(input logic [NT-1:0] m);
    sts_clr = 1'b1; sts_mask = m;
    @(negedge clk);
    sts_clr = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (expq.size() == 0) chk(1'b0, "R11 unexpected message", {msg_addr, msg_data}, '0);
      else eq("R10 message order/content", {msg_addr, msg_data}, expq.pop_front());
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    eq("R1 status", 64'(sts), 0);
    eq("R1 lines", 64'(irq), 0);
    eq("R1 valid", 64'(msg_valid), 0);
    cfg_rsel = 0; #1; eq("R1 cfg t0", cfg_rdata, {ALW, 32'h0000_8010});
    cfg_rsel = 3; #1; eq("R1 cfg t3", cfg_rdata, {ALW, 32'h0000_0010});

    // R7 / R6: all-ones write; route 31 illegal
    wr_cfg(0, 32'hFFFF_FFFF);
    cfg_rsel = 0; #1; eq("R7 R6 cfg readback", cfg_rdata, {ALW, 32'h0000_C01E});

    // R2 disabled
    wr_cfg(0, cw(0, 0, 20, 0));
    do_fire(4'b0001);
    eq("R2 lines", 64'(irq), 0);
    eq("R2 status", 64'(sts), 0);

    // R3 edge pulse
    wr_cfg(0, cw(0, 1, 20, 0));
    do_fire(4'b0001);
    eq("R3 pulse", 64'(irq), 64'(1) << 20);
    eq("R3 status", 64'(sts), 0);
    @(negedge clk);
    eq("R3 pulse ends", 64'(irq), 0);

    // R4 level hold
    wr_cfg(1, cw(1, 1, 21, 0));
    do_fire(4'b0010);
    eq("R4 status", 64'(sts), 64'h2);
    repeat (3) @(negedge clk);
    eq("R4 line held", 64'(irq), 64'(1) << 21);
    do_fire(4'b0010);
    eq("R4 refire ignored", 64'(sts), 64'h2);

    // R5 write-one-to-clear
    wr_cfg(2, cw(1, 1, 22, 0));
    do_fire(4'b0100);
    eq("R5 both held", 64'(irq), (64'(1) << 21) | (64'(1) << 22));
    clr(4'b0100);
    eq("R5 status", 64'(sts), 64'h2);
    eq("R5 line", 64'(irq), 64'(1) << 21);

    // R9 config-change drops
    wr_cfg(1, cw(1, 1, 21, 0));
    eq("R9 same rewrite keeps", 64'(sts), 64'h2);
    wr_cfg(1, cw(1, 1, 23, 0));
    eq("R9 route change", 64'(sts), 0);
    eq("R9 route change line", 64'(irq), 0);
    do_fire(4'b0010);
    eq("R9 rearm", 64'(irq), 64'(1) << 23);
    wr_cfg(1, cw(1, 0, 23, 0));
    eq("R9 disable", 64'(sts), 0);
    wr_cfg(1, cw(1, 1, 23, 0));
    do_fire(4'b0010);
    wr_cfg(1, cw(0, 1, 23, 0));
    eq("R9 to edge", 64'(sts), 0);
    wr_cfg(1, cw(1, 1, 23, 0));
    do_fire(4'b0010);
    wr_cfg(1, cw(1, 1, 23, 1));
    eq("R9 to message", 64'(sts), 0);
    eq("R9 to message line", 64'(irq), 0);

    // R6 illegal route
    wr_cfg(2, cw(1, 1, 5, 0));
    cfg_rsel = 2; #1; eq("R6 route field", 64'(cfg_rdata[13:9]), 0);
    do_fire(4'b0100);
    eq("R6 no status", 64'(sts), 0);
    eq("R6 no line", 64'(irq), 0);

    // R8 not-capable timer stays routed
    wr_cfg(3, cw(1, 1, 20, 1));
    cfg_rsel = 3; #1; eq("R8 cap clear", 64'(cfg_rdata[15:14]), 64'h1);
    do_fire(4'b1000);
    eq("R8 uncapable level", 64'(sts), 64'h8);
    eq("R8 uncapable line", 64'(irq), 64'(1) << 20);
    clr(4'b1000);

    // R8 message delivery
    wr_msg(0, 64'hFEE0_1000_0000_0041);
    wr_cfg(0, cw(1, 1, 20, 1));
    expq.push_back(64'hFEE0_1000_0000_0041);
    do_fire(4'b0001);
    eq("R8 no status", 64'(sts), 0);
    eq("R8 no line", 64'(irq), 0);
    repeat (4) @(negedge clk);
    eq("R8 delivered", 64'(expq.size()), 0);

    // R10 / R11 burst under back-pressure
    wr_msg(0, 64'hA000_0000_0000_00A0);
    wr_msg(1, 64'hA100_0000_0000_00A1);
    wr_msg(2, 64'hA200_0000_0000_00A2);
    wr_cfg(1, cw(0, 1, 0, 1));
    wr_cfg(2, cw(0, 1, 0, 1));
    msg_ready = 1'b0;
    expq.push_back(64'hA000_0000_0000_00A0);
    expq.push_back(64'hA100_0000_0000_00A1);
    expq.push_back(64'hA200_0000_0000_00A2);
    do_fire(4'b0111);
    repeat (3) @(negedge clk);
    eq("R10 first offer", {msg_addr, msg_data}, 64'hA000_0000_0000_00A0);
    eq("R10 valid stalled", 64'(msg_valid), 1);
    wr_msg(0, 64'hBBBB_0000_0000_00BB);
    do_fire(4'b0010);
    eq("R10 offer frozen", {msg_addr, msg_data}, 64'hA000_0000_0000_00A0);
    msg_ready = 1'b1;
    repeat (10) @(negedge clk);
    eq("R11 no duplicate", 64'(expq.size()), 0);
    eq("R10 drained", 64'(msg_valid), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule